// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This block forms the effective address and the updated pointer value for one load or store of a processor's address unit. It takes a base register and a companion register. The companion holds a 16-bit index in its low half and a 16-bit parameter in its high half. It also takes a raw 10-bit signed offset and a 2-bit mode code.

Four modes are supported:
- A plain base-plus-offset mode.
- A post-increment mode that moves the base.
- A reversed-carry mode that steps the index the way FFT buffers need.
- A ring-buffer mode that wraps the index inside a buffer of given length.

All arithmetic is combinational. An optional register stage (on by default) holds the results for one clock, so the register file and memory pipeline can pick them up on the next edge. The caller writes back only the register whose write-enable is raised.

Top module: `addr_step_unit`

## Requirements
- R1: With mode code 0 (offset), the effective address is base plus the sign-extended 10-bit offset, and neither write-enable is raised.
- R2: With mode code 1 (post-increment), the effective address is the unmodified base. The new base equals base plus the sign-extended offset, and only the base write-enable is raised.
- R3: With mode code 2 (reversed carry), the effective address is base plus the zero-extended companion bits [15:0].
- R4: With mode code 2, the new companion holds the step (bits [31:16]) unchanged. Its bits [15:0] hold rev(rev(index)+rev(step)) modulo 2^16, where rev mirrors 16 bits. Only the companion write-enable is raised.
- R5: With mode code 3 (ring buffer), the effective address is base plus the old index taken from companion bits [15:0].
- R6: With mode code 3 and a nonzero length in bits [31:16], let s = index + sign-extended offset. The new index is s+length when s is negative, s-length when s is at least the length, and s otherwise. The length is kept in bits [31:16], and only the companion write-enable is raised. This holds for an offset magnitude no larger than the length.
- R7: With mode code 3 and a length of zero, the companion index is returned unchanged.
- R8: At most one write-enable is raised at a time, and none when the result is not valid.
- R9: Results appear one clock after the inputs are presented. A synchronous active-high reset clears the valid flag, both write-enables and the data outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| mode | input | 2 | Addressing mode code 0..3 |
| base | input | 32 | Base register value |
| pair | input | 32 | Companion register: parameter [31:16], index [15:0] |
| offset | input | 10 | Raw signed offset |
| out_valid | output | 1 | Results valid |
| ea | output | 32 | Effective address |
| new_base | output | 32 | Value to write back to the base register |
| new_pair | output | 32 | Value to write back to the companion register |
| base_we | output | 1 | Write new_base back |
| pair_we | output | 1 | Write new_pair back |

## Verification
On every cycle, the assertions check:
- the one-cycle valid latency;
- mutual exclusion of the write-enables and their silence when idle;
- that the offset mode writes nothing;
- the post-increment address;
- preservation of the companion high half;
- the zero-length ring case.

The arithmetic results can only be shown by the bench's reference model, compared against the design on every clock:
- the reversed-carry index sequence;
- the negative and overflowing ring wraps;
- sign extension of negative offsets.

// File: rtl/addr_step_pkg.sv
package addr_step_pkg;
  typedef enum logic [1:0] {
    AM_OFFSET  = 2'd0,
    AM_POSTINC = 2'd1,
    AM_BITREV  = 2'd2,
    AM_RING    = 2'd3
  } am_e;
endpackage

// File: rtl/brev_step.sv
module brev_step #(
  parameter int HW = 16
) (
  input  logic [HW-1:0] idx,
  input  logic [HW-1:0] step,
  output logic [HW-1:0] nxt
);
  logic [HW-1:0] r_idx, r_step, r_sum;

  for (genvar k = 0; k < HW; k++) begin : g_mirror_in
    assign r_idx[k]  = idx[HW-1-k];
    assign r_step[k] = step[HW-1-k];
  end

  assign r_sum = r_idx + r_step;

  for (genvar k = 0; k < HW; k++) begin : g_mirror_out
    assign nxt[k] = r_sum[HW-1-k];
  end
endmodule

// File: rtl/ring_step.sv
module ring_step #(
  parameter int HW = 16,
  parameter int OW = 10
) (
  input  logic [HW-1:0] idx,
  input  logic [HW-1:0] len,
  input  logic [OW-1:0] off,
  output logic [HW-1:0] nxt
);
  localparam int SW = HW + 2;

  logic signed [SW-1:0] sum, len_s, up, dn;

  assign len_s = $signed({2'b00, len});
  assign sum   = $signed({2'b00, idx}) + $signed({{(SW-OW){off[OW-1]}}, off});
  assign up    = sum + len_s;
  assign dn    = sum - len_s;

  always_comb begin
    if (len == '0)           nxt = idx;
    else if (sum < 0)        nxt = up[HW-1:0];
    else if (sum >= len_s)   nxt = dn[HW-1:0];
    else                     nxt = sum[HW-1:0];
  end
endmodule

// File: rtl/addr_step_unit.sv
module addr_step_unit
  import addr_step_pkg::*;
#(
  parameter int AW      = 32,
  parameter int HW      = 16,
  parameter int OW      = 10,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      mode,
  input  logic [AW-1:0]   base,
  input  logic [2*HW-1:0] pair,
  input  logic [OW-1:0]   offset,
  output logic            out_valid,
  output logic [AW-1:0]   ea,
  output logic [AW-1:0]   new_base,
  output logic [2*HW-1:0] new_pair,
  output logic            base_we,
  output logic            pair_we
);
  localparam int PW = 2 * HW;

  am_e            am;
  logic [AW-1:0]  off_ext, idx_ext;
  logic [HW-1:0]  lo, hi, brev_nxt, ring_nxt;
  logic [AW-1:0]  c_ea, c_nb;
  logic [PW-1:0]  c_np;
  logic           c_bwe, c_pwe;

  assign am      = am_e'(mode);
  assign lo      = pair[HW-1:0];
  assign hi      = pair[PW-1:HW];
  assign off_ext = {{(AW-OW){offset[OW-1]}}, offset};
  assign idx_ext = {{(AW-HW){1'b0}}, lo};

  brev_step #(.HW(HW)) u_brev (
    .idx (lo),
    .step(hi),
    .nxt (brev_nxt)
  );

  ring_step #(.HW(HW), .OW(OW)) u_ring (
    .idx(lo),
    .len(hi),
    .off(offset),
    .nxt(ring_nxt)
  );

  always_comb begin
    c_nb  = base + off_ext;
    c_np  = pair;
    c_bwe = 1'b0;
    c_pwe = 1'b0;
    unique case (am)
      AM_OFFSET:  c_ea = base + off_ext;
      AM_POSTINC: begin
        c_ea  = base;
        c_bwe = in_valid;
      end
      AM_BITREV: begin
        c_ea  = base + idx_ext;
        c_np  = {hi, brev_nxt};
        c_pwe = in_valid;
      end
      default: begin
        c_ea  = base + idx_ext;
        c_np  = {hi, ring_nxt};
        c_pwe = in_valid;
      end
    endcase
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        ea        <= '0;
        new_base  <= '0;
        new_pair  <= '0;
        base_we   <= 1'b0;
        pair_we   <= 1'b0;
      end else begin
        out_valid <= in_valid;
        ea        <= c_ea;
        new_base  <= c_nb;
        new_pair  <= c_np;
        base_we   <= c_bwe;
        pair_we   <= c_pwe;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign ea        = c_ea;
    assign new_base  = c_nb;
    assign new_pair  = c_np;
    assign base_we   = c_bwe;
    assign pair_we   = c_pwe;
  end
endmodule

// File: rtl/addr_step_chk.sv
module addr_step_chk #(
  parameter int AW      = 32,
  parameter int HW      = 16,
  parameter int OW      = 10,
  parameter bit OUT_REG = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [1:0]      mode,
  input logic [AW-1:0]   base,
  input logic [2*HW-1:0] pair,
  input logic [OW-1:0]   offset,
  input logic            out_valid,
  input logic [AW-1:0]   ea,
  input logic [AW-1:0]   new_base,
  input logic [2*HW-1:0] new_pair,
  input logic            base_we,
  input logic            pair_we
);
  localparam int PW = 2 * HW;

  if (OUT_REG) begin : g_seq
    // R8: never both enables
    a_r8_one_enable: assert property (@(posedge clk) disable iff (rst)
      !(base_we && pair_we));

    // R8: idle cycle writes nothing
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (!base_we && !pair_we));

    // R9: one-cycle latency of valid
    a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid == $past(in_valid)));

    // R1: offset mode writes no register
    a_r1_no_write: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(mode) == 2'd0) |-> (!base_we && !pair_we));

    // R2: post-increment uses the old base as address
    a_r2_post_addr: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(mode) == 2'd1) |-> (ea == $past(base) && base_we));

    // R4 / R6: companion high half survives write-back
    a_r6_keep_high: assert property (@(posedge clk) disable iff (rst)
      pair_we |-> (new_pair[PW-1:HW] == $past(pair[PW-1:HW])));

    // R7: zero length leaves the index alone
    a_r7_zero_len: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(mode) == 2'd3 && $past(pair[PW-1:HW]) == '0)
        |-> (new_pair[HW-1:0] == $past(pair[HW-1:0])));
  end else begin : g_comb
    always_comb begin
      if (!rst) begin
        a_r8_one_enable_c: assert (!(base_we && pair_we));
      end
    end
  end
endmodule

bind addr_step_unit addr_step_chk #(
  .AW(AW), .HW(HW), .OW(OW), .OUT_REG(OUT_REG)
) u_addr_step_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .base(base),
  .pair(pair), .offset(offset), .out_valid(out_valid), .ea(ea),
  .new_base(new_base), .new_pair(new_pair), .base_we(base_we), .pair_we(pair_we)
);

// File: tb/test_addr_step_unit.sv
module test_addr_step_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  mode;
  logic [31:0] base, pair;
  logic [9:0]  offset;
  logic        out_valid, base_we, pair_we;
  logic [31:0] ea, new_base, new_pair;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        e_v, e_bwe, e_pwe;
  logic [1:0]  e_mode;
  logic [31:0] e_ea, e_nb, e_np;
  bit          e_zero_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_step_unit i_addr_step_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .base(base),
    .pair(pair), .offset(offset), .out_valid(out_valid), .ea(ea),
    .new_base(new_base), .new_pair(new_pair), .base_we(base_we), .pair_we(pair_we)
  );

  function automatic logic [15:0] mirror(input logic [15:0] x);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[k] = x[15-k];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(out_valid == e_v, "R9 valid", 32'(out_valid), 32'(e_v));
    if (e_v) begin
      chk(base_we == e_bwe, "R8 base_we", 32'(base_we), 32'(e_bwe));
      chk(pair_we == e_pwe, "R8 pair_we", 32'(pair_we), 32'(e_pwe));
      case (e_mode)
        2'd0: chk(ea == e_ea, "R1 ea", ea, e_ea);
        2'd1: begin
          chk(ea == e_ea, "R2 ea", ea, e_ea);
          chk(new_base == e_nb, "R2 new_base", new_base, e_nb);
        end
        2'd2: begin
          chk(ea == e_ea, "R3 ea", ea, e_ea);
          chk(new_pair == e_np, "R4 new_pair", new_pair, e_np);
        end
        default: begin
          chk(ea == e_ea, "R5 ea", ea, e_ea);
          if (e_zero_len) chk(new_pair == e_np, "R7 new_pair", new_pair, e_np);
          else            chk(new_pair == e_np, "R6 new_pair", new_pair, e_np);
        end
      endcase
    end else begin
      chk(!base_we && !pair_we, "R8 idle enables", {30'd0, base_we, pair_we}, 32'd0);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] m, input logic [31:0] b,
                      input logic [31:0] p, input logic [9:0] o);
    int so, idx, len, s, n;
    @(negedge clk);
    compare();
    in_valid = v; mode = m; base = b; pair = p; offset = o;
    so  = $signed(o);
    idx = int'(p[15:0]);
    len = int'(p[31:16]);
    e_v = v; e_mode = m; e_bwe = v && (m == 2'd1); e_pwe = v && (m >= 2'd2);
    e_nb = b + 32'(so); e_np = p; e_zero_len = (len == 0);
    case (m)
      2'd0: e_ea = b + 32'(so);
      2'd1: e_ea = b;
      2'd2: begin
        e_ea = b + 32'(idx);
        e_np = {p[31:16], mirror(mirror(p[15:0]) + mirror(p[31:16]))};
      end
      default: begin
        e_ea = b + 32'(idx);
        if (len == 0) n = idx;
        else begin
          s = idx + so;
          n = (s < 0) ? s + len : s % len;
        end
        e_np = {p[31:16], 16'(n)};
      end
    endcase
  endtask

  initial begin
    int lim, o, len;
    rst = 1'b1; in_valid = 1'b0; mode = 2'd0; base = '0; pair = '0; offset = '0;
    e_v = 1'b0; e_mode = 2'd0; e_bwe = 1'b0; e_pwe = 1'b0;
    e_ea = '0; e_nb = '0; e_np = '0; e_zero_len = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !base_we && !pair_we, "R9 reset flags", {29'd0, out_valid, base_we, pair_we}, 32'd0);
    chk(ea == 32'd0 && new_pair == 32'd0, "R9 reset data", ea | new_pair, 32'd0);
    rst = 1'b0;
    // directed corners
    step(1, 2'd0, 32'h0000_0000, 32'h1234_5678, 10'h3FF);   // R1 negative offset
    step(1, 2'd0, 32'h8000_0000, 32'h0, 10'h1FF);           // R1 max positive
    step(1, 2'd1, 32'h0000_1000, 32'h0, 10'h200);           // R2 most negative
    step(0, 2'd1, 32'h0000_1000, 32'h0, 10'h004);           // R8 idle
    step(1, 2'd2, 32'h4000_0000, 32'h0001_0000, 10'h0);     // R4 step 1
    step(1, 2'd2, 32'h4000_0000, 32'h0008_000C, 10'h0);     // R4 carry
    step(1, 2'd2, 32'h4000_0000, 32'hFFFF_FFFF, 10'h0);     // R4 wrap
    step(1, 2'd3, 32'h2000_0000, 32'h0008_0002, 10'h3FB);   // R6 negative -> add
    step(1, 2'd3, 32'h2000_0000, 32'h0008_0006, 10'h004);   // R6 over -> sub
    step(1, 2'd3, 32'h2000_0000, 32'h0008_0007, 10'h001);   // R6 exactly length
    step(1, 2'd3, 32'h2000_0000, 32'h0008_0003, 10'h002);   // R6 in range
    step(1, 2'd3, 32'h2000_0000, 32'h0000_007B, 10'h011);   // R7 zero length
    // reversed-carry sequence walk
    for (int k = 0; k < 20; k++) begin
      logic [15:0] cur;
      cur = 16'(k * 4);
      step(1, 2'd2, 32'h100, {16'h0010, cur}, 10'h0);
    end
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [1:0] m;
      logic [31:0] b, p;
      m = 2'($urandom);
      b = $urandom;
      p = $urandom;
      o = int'($urandom % 1024) - 512;
      if (m == 2'd3) begin
        len = 1 + int'($urandom % 3000);
        lim = (len < 511) ? len : 511;
        o = int'($urandom % 32'(2*lim + 1)) - lim;
        p = {16'(len), 16'(int'($urandom % 32'(len)))};
      end
      step(($urandom % 8) != 0, m, b, p, 10'(o));
    end
    step(0, 2'd0, 32'h0, 32'h0, 10'h0);
    step(0, 2'd0, 32'h0, 32'h0, 10'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule